// File: doc/BRIEF.md
# Selectable Periodic Interrupt Divider

This block turns an oscillator time base into a periodic interrupt and an optional square wave. A 3-bit time-base selector picks the prescale factor that brings the oscillator down to a common base rate. Selector values that do not name a time base hold the whole divider cleared. A 4-bit rate selector then picks a power-of-two tap on the divider, or turns the periodic output off. Each expiry of the chosen period sets a sticky periodic flag. When the periodic interrupt enable is set, that flag also raises a summary interrupt request. A host read of the status register clears both.

The oscillator is modelled as a one-cycle enable pulse on the system clock, and the divider advances only on those cycles. All periods below are given in oscillator ticks. A base tick is one prescaled step: 128 oscillator ticks for the fast base, 32 for the middle base and 1 for the slow base. The square wave has a 50% duty cycle at the periodic rate. It is low in the first half of each period.

Top module: `periodic_irq_divider`

## Requirements
- R1: Time-base selector 3'b000 prescales by 128 oscillator ticks, 3'b001 by 32, and 3'b010 by 1. Every other value (including 3'b011, 3'b110 and 3'b111) holds the divider cleared, sets no flag and keeps `sqw_out` low.
- R2: Rate codes 3 to 15 give a period of 2^(code-1) base ticks: 4 base ticks for code 3, doubling with each code up to 16384 for code 15.
- R3: Rate codes 1 and 2 give periods of 128 and 256 oscillator ticks with selector 3'b010. With selectors 3'b000 and 3'b001 they give periods of 1 and 2 base ticks.
- R4: Rate code 0 never sets the periodic flag and keeps `sqw_out` low.
- R5: A period expiry sets `per_flag`, which stays set across later periods until a status read.
- R6: A cycle with `status_rd` high clears `per_flag` and `irq_sum` at that clock edge. If a period expiry falls on the same edge, the flag is set instead.
- R7: `irq_sum` is high exactly when `per_flag` and `per_irq_en` are both high, and it follows `per_irq_en` in the same cycle.
- R8: With `sqw_en` high and a nonzero rate on a running time base, `sqw_out` is a 50% duty wave whose period equals the flag period, low during the first half. With `sqw_en` low, `sqw_out` is low.
- R9: The divider advances only on cycles with `osc_tick` high. With a tick every other cycle, each period lasts twice as many clock cycles.
- R10: When the selector moves from a holding value to a time base, the first expiry comes exactly one full period later: `per_flag` is visible after the P-th ticked clock edge, where P is the period in ticks.
- R11: After reset, `per_flag`, `irq_sum` and `sqw_out` are low and the divider is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator edge |
| tbase_sel | input | 3 | Time-base selector, or a holding value |
| rate_sel | input | 4 | Periodic rate code, 0 turns the output off |
| per_irq_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| status_rd | input | 1 | Host read of the status register, clears the flags |
| per_flag | output | 1 | Sticky periodic flag |
| irq_sum | output | 1 | Summary interrupt request |
| sqw_out | output | 1 | Square-wave output |

## Verification
The hardest case to reach from the ports is a status read that lands on the same edge as a period expiry. With a free-running divider, that edge cannot be predicted. The stimulus always starts from a holding selector value, so the divider begins from zero at a known edge. It keeps `status_rd` high throughout, so that every expiry collides with a read. The flag must then show as a one-cycle pulse, one period apart, and the exact arrival of the first pulse also checks the full-period start. The sticky-flag scenario starts from the same known point. It issues a read between expiries, where no collision can happen.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    localparam int TAP_W          = 6;
    // log2 of the slow-base period for rate code 1 (code 2 is one more)
    localparam int SLOW_CODE1_LOG = 7;

    typedef enum logic [2:0] {
        TB_FAST = 3'b000,
        TB_MID  = 3'b001,
        TB_SLOW = 3'b010
    } tbase_e;

    typedef struct packed {
        logic             run;     // divider allowed to count
        logic             active;  // a periodic tap is selected
        logic [TAP_W-1:0] span;    // log2 of the period in oscillator ticks
    } tap_t;

    function automatic tap_t tap_decode(
        input logic [2:0] tb,
        input logic [3:0] rate,
        input int         sh_fast,
        input int         sh_mid,
        input int         sh_slow
    );
        tap_t t;
        int   pre;
        int   k;
        t.run = 1'b1;
        pre   = 0;
        case (tb)
            TB_FAST: pre = sh_fast;
            TB_MID:  pre = sh_mid;
            TB_SLOW: pre = sh_slow;
            default: t.run = 1'b0;
        endcase
        if (tb == TB_SLOW && rate == 4'd1)      k = SLOW_CODE1_LOG;
        else if (tb == TB_SLOW && rate == 4'd2) k = SLOW_CODE1_LOG + 1;
        else                                    k = int'(rate) - 1;
        t.active = t.run && (rate != 4'd0);
        t.span   = t.active ? TAP_W'(pre + k) : '0;
        return t;
    endfunction

endpackage

// File: rtl/pdiv_tap_dec.sv
module pdiv_tap_dec
    import pdiv_pkg::*;
#(
    parameter int SH_FAST = 7,
    parameter int SH_MID  = 5,
    parameter int SH_SLOW = 0
) (
    input  logic [2:0] tbase_sel,
    input  logic [3:0] rate_sel,
    output tap_t       tap
);

    always_comb tap = tap_decode(tbase_sel, rate_sel, SH_FAST, SH_MID, SH_SLOW);

endmodule

// File: rtl/pdiv_chain.sv
module pdiv_chain
    import pdiv_pkg::*;
#(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             active,
    input  logic [TAP_W-1:0] span,
    output logic             evt,
    output logic             half
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    always_comb begin
        for (int i = 0; i < CNT_W; i++) mask[i] = (TAP_W'(i) < span);
    end

    always_comb evt = run && active && tick && ((cnt & mask) == mask);

    // top bit of the selected window: low for the first half of each period
    always_comb begin
        half = 1'b0;
        for (int i = 1; i <= CNT_W; i++) begin
            if (active && span == TAP_W'(i)) half = cnt[i-1];
        end
    end

    // R9
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick) |=> (cnt == $past(cnt) || cnt == '0));

    // R1
    held_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!run) |=> (!run || cnt <= CNT_W'(1)));

endmodule

// File: rtl/pdiv_flags.sv
module pdiv_flags (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic status_rd,
    input  logic per_irq_en,
    output logic per_flag,
    output logic irq_sum
);

    always_ff @(posedge clk) begin
        if (rst)            per_flag <= 1'b0;
        else if (evt)       per_flag <= 1'b1;
        else if (status_rd) per_flag <= 1'b0;
    end

    always_comb irq_sum = per_flag && per_irq_en;

    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !evt) |=> !per_flag);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> per_flag);

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (per_flag && !status_rd) |=> per_flag);

endmodule

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider
    import pdiv_pkg::*;
#(
    parameter int SH_FAST   = 7,
    parameter int SH_MID    = 5,
    parameter int SH_SLOW   = 0,
    parameter int CHAIN_LOG = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic [2:0] tbase_sel,
    input  logic [3:0] rate_sel,
    input  logic       per_irq_en,
    input  logic       sqw_en,
    input  logic       status_rd,
    output logic       per_flag,
    output logic       irq_sum,
    output logic       sqw_out
);

    localparam int SH_MAX0 = (SH_FAST > SH_MID) ? SH_FAST : SH_MID;
    localparam int SH_MAX  = (SH_MAX0 > SH_SLOW) ? SH_MAX0 : SH_SLOW;
    localparam int CNT_W   = SH_MAX + CHAIN_LOG;

    tap_t tap;
    logic evt;
    logic half;

    pdiv_tap_dec #(
        .SH_FAST (SH_FAST),
        .SH_MID  (SH_MID),
        .SH_SLOW (SH_SLOW)
    ) u_dec (
        .tbase_sel (tbase_sel),
        .rate_sel  (rate_sel),
        .tap       (tap)
    );

    pdiv_chain #(
        .CNT_W (CNT_W)
    ) u_chain (
        .clk    (clk),
        .rst    (rst),
        .tick   (osc_tick),
        .run    (tap.run),
        .active (tap.active),
        .span   (tap.span),
        .evt    (evt),
        .half   (half)
    );

    pdiv_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .status_rd  (status_rd),
        .per_irq_en (per_irq_en),
        .per_flag   (per_flag),
        .irq_sum    (irq_sum)
    );

    always_comb sqw_out = sqw_en && half;

    // R1
    held_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (!tap.run) |-> (!evt && !sqw_out));

    // R4
    rate_off_chk: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 4'd0) |-> (!sqw_out && !evt));

    // R7
    sum_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_sum |-> per_flag);

    // R8
    sqw_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!sqw_en) |-> !sqw_out);

endmodule

// File: tb/sim_periodic_irq_divider.sv
module sim_periodic_irq_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b1;
    logic [2:0] tbase_sel = 3'b110;
    logic [3:0] rate_sel = 4'd0;
    logic       per_irq_en = 1'b1;
    logic       sqw_en = 1'b0;
    logic       status_rd = 1'b0;
    logic       per_flag;
    logic       irq_sum;
    logic       sqw_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int tick_div = 1;
    logic [7:0] tick_ph = '0;

    always #5 clk = ~clk;

    periodic_irq_divider u0 (
        .clk        (clk),
        .rst        (rst),
        .osc_tick   (osc_tick),
        .tbase_sel  (tbase_sel),
        .rate_sel   (rate_sel),
        .per_irq_en (per_irq_en),
        .sqw_en     (sqw_en),
        .status_rd  (status_rd),
        .per_flag   (per_flag),
        .irq_sum    (irq_sum),
        .sqw_out    (sqw_out)
    );

    always @(negedge clk) begin
        tick_ph  <= tick_ph + 8'd1;
        osc_tick <= (tick_div == 1) ? 1'b1 : (tick_ph[0] == 1'b0);
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycles %0d expected below 190000", cyc);
            summary();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold_then_start(input logic [2:0] tb, input logic [3:0] rate, input logic rd);
        @(negedge clk);
        tbase_sel = 3'b110;
        rate_sel  = rate;
        status_rd = 1'b1;
        repeat (3) @(negedge clk);
        status_rd = rd;
        tbase_sel = tb;
    endtask

    // R11
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R11 flag", int'(per_flag), 0);
        check("R11 sum", int'(irq_sum), 0);
        check("R11 sqw", int'(sqw_out), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // R2 R3 R10 R6 R9: measures first arrival and one interval with reads held
    task automatic t_rate(input string req, input logic [2:0] tb, input logic [3:0] rate,
                          input int per, input bit chk_first);
        int n;
        int m;
        bit got;
        hold_then_start(tb, rate, 1'b1);
        n = 0;
        got = 0;
        while (!got && n < 3 * per + 20) begin
            @(posedge clk); #2;
            n++;
            if (per_flag) got = 1;
        end
        if (chk_first) check({req, " R10 first period"}, n, per);
        else           check({req, " flag seen"}, int'(got), 1);
        @(posedge clk); #2;
        check({req, " R6 read clears after collision pulse"}, int'(per_flag), 0);
        m = 1;
        got = 0;
        while (!got && m < 3 * per + 20) begin
            @(posedge clk); #2;
            m++;
            if (per_flag) got = 1;
        end
        check({req, " interval"}, m, per);
    endtask

    // R1: non-base selector values hold everything quiet
    task automatic t_hold(input logic [2:0] code);
        int seen_f;
        int seen_s;
        @(negedge clk);
        tbase_sel = code;
        rate_sel  = 4'd3;
        sqw_en    = 1'b1;
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        seen_f = 0;
        seen_s = 0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); #2;
            if (per_flag) seen_f++;
            if (sqw_out) seen_s++;
        end
        check("R1 held flag count", seen_f, 0);
        check("R1 held sqw count", seen_s, 0);
        sqw_en = 1'b0;
    endtask

    // R4
    task automatic t_rate_off();
        int seen_f;
        int seen_s;
        hold_then_start(3'b010, 4'd0, 1'b0);
        sqw_en = 1'b1;
        seen_f = 0;
        seen_s = 0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); #2;
            if (per_flag) seen_f++;
            if (sqw_out) seen_s++;
        end
        check("R4 flag count", seen_f, 0);
        check("R4 sqw count", seen_s, 0);
        sqw_en = 1'b0;
    endtask

    // R5 R6 R7: sticky flag, read between expiries, enable gating
    task automatic t_sticky();
        per_irq_en = 1'b1;
        hold_then_start(3'b010, 4'd6, 1'b0);
        for (int k = 1; k <= 67; k++) begin
            @(posedge clk); #2;
            if (k == 31) check("R5 before expiry", int'(per_flag), 0);
            if (k == 32) check("R7 sum with enable", int'(irq_sum), 1);
            if (k == 40) check("R5 sticky", int'(per_flag), 1);
            if (k == 40) status_rd = 1'b1;
            if (k == 41) begin
                check("R6 read clears flag", int'(per_flag), 0);
                check("R6 read clears sum", int'(irq_sum), 0);
                status_rd = 1'b0;
            end
            if (k == 63) check("R5 still clear", int'(per_flag), 0);
            if (k == 64) check("R5 set again", int'(per_flag), 1);
            if (k == 65) per_irq_en = 1'b0;
            if (k == 66) begin
                check("R7 sum off", int'(irq_sum), 0);
                check("R7 flag kept", int'(per_flag), 1);
                per_irq_en = 1'b1;
            end
            if (k == 67) check("R7 sum back", int'(irq_sum), 1);
        end
    endtask

    // R8
    task automatic t_sqw();
        int highs;
        hold_then_start(3'b010, 4'd3, 1'b1);
        sqw_en = 1'b1;
        highs = 0;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk); #2;
            check("R8 wave", int'(sqw_out), (k >> 1) & 1);
            if (sqw_out) highs++;
        end
        check("R8 duty", highs, 4);
        @(negedge clk);
        sqw_en = 1'b0;
        highs = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #2;
            if (sqw_out) highs++;
        end
        check("R8 disabled", highs, 0);
    endtask

    initial begin
        t_reset();
        t_rate("R2 slow code3", 3'b010, 4'd3, 4, 1);
        t_rate("R2 slow code6", 3'b010, 4'd6, 32, 1);
        t_rate("R2 slow code15", 3'b010, 4'd15, 16384, 1);
        t_rate("R2 fast code3", 3'b000, 4'd3, 512, 1);
        t_rate("R3 slow code1", 3'b010, 4'd1, 128, 1);
        t_rate("R3 slow code2", 3'b010, 4'd2, 256, 1);
        t_rate("R3 mid code1", 3'b001, 4'd1, 32, 1);
        t_rate("R3 mid code2", 3'b001, 4'd2, 64, 1);
        t_rate("R3 fast code1", 3'b000, 4'd1, 128, 1);
        t_hold(3'b110);
        t_hold(3'b111);
        t_hold(3'b011);
        t_rate_off();
        t_sticky();
        t_sqw();
        tick_div = 2;
        t_rate("R9 half ticks", 3'b010, 4'd3, 8, 0);
        tick_div = 1;
        summary();
    end

endmodule